// File: doc/BRIEF.md
# Timestamp Phase Error Detector

This block compares a locally running system time clock (STC) with the program clock reference (PCR) samples that a receiver extracts from a transport stream. It turns the outcome into a signed phase error for a clock-recovery loop. Each timestamp arrives as a 33-bit base count and a 9-bit extension count (0 to 299). The block folds each one into a single binary count, base × 300 + extension. It can discard a chosen number of low bits from both counts. It then subtracts the PCR count from the STC count.

The difference is read as a two's-complement number whose sign sits at a configurable bit position. From it the block produces a windowed error, optionally scaled down by an arithmetic right shift, plus two flags. The in-range flag says the difference fits the comparison window. The lock flag says it fits a second, independently sized window. A strobe marks each new PCR sample. The results appear two clocks later and stay unchanged until the next strobe has been processed.

Top module: `ts_phase_detector`

## Requirements
- R1: Each timestamp is converted to the count base × 300 + extension, exactly, over the whole 33-bit base range.
- R2: Both counts are shifted right by `cfg_drop` (0..15) bits before subtraction, so that many low bits take no part in the error or the flags.
- R3: The difference is D = (STC count >> drop) − (PCR count >> drop) in two's complement. With n = `cfg_width`, the raw error is bits n..0 of D sign-extended from bit n to 16 bits.
- R4: `in_range` is 1 exactly when D lies in [−2^n, 2^n − 1], that is, when every bit of D above bit n equals bit n.
- R5: `lock_flag` is 1 exactly when D lies in [−2^m, 2^m − 1] with m = `cfg_lock`. The result is independent of `cfg_width`.
- R6: When `sel_gain` = 1, `err_out` is the raw error shifted right arithmetically by `cfg_gain` bits, which rounds toward minus infinity.
- R7: When `sel_gain` = 0, `err_out` is the raw error, and `cfg_gain` has no effect.
- R8: All inputs and configuration are captured on the rising edge where `sample_valid` is 1. `err_out`, `in_range` and `lock_flag` change on the following rising edge, and `out_valid` is high for that one cycle.
- R9: Between strobes, the outputs hold their values whatever the timestamp and configuration inputs do, and `out_valid` stays 0.
- R10: Synchronous active-high reset clears `err_out`, `in_range`, `lock_flag` and `out_valid` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_valid | input | 1 | Strobe marking a new PCR sample |
| stc_base | input | 33 | Local clock base count |
| stc_ext | input | 9 | Local clock extension count (0..299) |
| pcr_base | input | 33 | Received reference base count |
| pcr_ext | input | 9 | Received reference extension count (0..299) |
| cfg_drop | input | 4 | Number of low bits discarded before subtraction |
| cfg_width | input | 4 | Sign-bit position n of the comparison window |
| cfg_lock | input | 4 | Sign-bit position m of the lock window |
| cfg_gain | input | 4 | Arithmetic right-shift amount for the scaled path |
| sel_gain | input | 1 | 1 selects the scaled error, 0 the raw windowed error |
| err_out | output | 16 | Two's-complement phase error |
| in_range | output | 1 | Difference fits the comparison window |
| lock_flag | output | 1 | Difference fits the lock window |
| out_valid | output | 1 | One-cycle pulse when results are updated |

## Verification
The bench probes each window at its four edges: 2^n − 1, 2^n, −2^n and −2^n − 1. An off-by-one in the upper-bit rule would flip `in_range` or `lock_flag` at exactly one of these points, and a wrongly placed sign bit would wrap the error to the opposite sign. An extension of 299 against a base one count higher checks that the ×300 fold carries correctly. A maximum-size base checks that no conversion bit is lost. A negative odd error under gain shows whether the shift is arithmetic and floors: a logical or rounding shift gives a large positive value or −9 instead of −10. Further tests cover the bits discarded by `cfg_drop`, the swap of one window against the other, and inputs that change without a strobe. They catch a design that shifts only one count, shares one threshold between the two flags, or leaks new inputs into the held outputs.

// File: rtl/ts_pd_pkg.sv
package ts_pd_pkg;
  localparam int CFG_W = 4;

  typedef struct packed {
    logic [CFG_W-1:0] drop;
    logic [CFG_W-1:0] width;
    logic [CFG_W-1:0] lock;
    logic [CFG_W-1:0] gain;
    logic             sel_gain;
  } pd_cfg_t;
endpackage

// File: rtl/ts_pd_convert.sv
module ts_pd_convert #(
  parameter int BASE_W = 33,
  parameter int EXT_W  = 9,
  parameter int CNT_W  = 42
) (
  input  logic [BASE_W-1:0] base,
  input  logic [EXT_W-1:0]  ext,
  output logic [CNT_W-1:0]  cnt
);
  logic [CNT_W-1:0] b;
  logic [CNT_W-1:0] e;

  always_comb begin
    b = CNT_W'(base);
    e = CNT_W'(ext);
    // 300 = 256 + 32 + 8 + 4
    cnt = (b << 8) + (b << 5) + (b << 3) + (b << 2) + e;
  end
endmodule

// File: rtl/ts_pd_window.sv
module ts_pd_window #(
  parameter int DIFF_W = 43,
  parameter int CFG_W  = 4
) (
  input  logic [DIFF_W-1:0] diff,
  input  logic [CFG_W-1:0]  thr,
  output logic              fits
);
  logic signed [DIFF_W-1:0] upper;

  always_comb begin
    upper = $signed(diff) >>> thr;
    fits  = (upper == '0) || (upper == '1);
  end
endmodule

// File: rtl/ts_pd_scale.sv
module ts_pd_scale #(
  parameter int DIFF_W = 43,
  parameter int CFG_W  = 4,
  parameter int ERR_W  = 16
) (
  input  logic [DIFF_W-1:0] diff,
  input  logic [CFG_W-1:0]  width,
  input  logic [CFG_W-1:0]  gain,
  input  logic              sel_gain,
  output logic [ERR_W-1:0]  err
);
  logic [ERR_W-1:0]        raw;
  logic signed [ERR_W-1:0] scaled;
  logic                    sgn;

  always_comb begin
    sgn = diff[width];
    for (int i = 0; i < ERR_W; i++) begin
      raw[i] = (i <= int'(width)) ? diff[i] : sgn;
    end
    scaled = $signed(raw) >>> gain;
    err    = sel_gain ? scaled : raw;
  end
endmodule

// File: rtl/ts_phase_detector.sv
module ts_phase_detector #(
  parameter int BASE_W = 33,
  parameter int EXT_W  = 9,
  parameter int ERR_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample_valid,
  input  logic [BASE_W-1:0] stc_base,
  input  logic [EXT_W-1:0]  stc_ext,
  input  logic [BASE_W-1:0] pcr_base,
  input  logic [EXT_W-1:0]  pcr_ext,
  input  logic [3:0]        cfg_drop,
  input  logic [3:0]        cfg_width,
  input  logic [3:0]        cfg_lock,
  input  logic [3:0]        cfg_gain,
  input  logic              sel_gain,
  output logic [ERR_W-1:0]  err_out,
  output logic              in_range,
  output logic              lock_flag,
  output logic              out_valid
);
  import ts_pd_pkg::*;

  localparam int CNT_W  = BASE_W + 9;
  localparam int DIFF_W = CNT_W + 1;

  logic [CNT_W-1:0]  stc_cnt;
  logic [CNT_W-1:0]  pcr_cnt;
  logic [DIFF_W-1:0] diff_c;
  pd_cfg_t           cfg_in;

  logic              s1_valid;
  logic [DIFF_W-1:0] s1_diff;
  pd_cfg_t           s1_cfg;

  logic              fit_win;
  logic              fit_lock;
  logic [ERR_W-1:0]  err_c;

  ts_pd_convert #(.BASE_W(BASE_W), .EXT_W(EXT_W), .CNT_W(CNT_W)) u_conv_stc (
    .base(stc_base), .ext(stc_ext), .cnt(stc_cnt)
  );

  ts_pd_convert #(.BASE_W(BASE_W), .EXT_W(EXT_W), .CNT_W(CNT_W)) u_conv_pcr (
    .base(pcr_base), .ext(pcr_ext), .cnt(pcr_cnt)
  );

  always_comb begin
    cfg_in = '{drop: cfg_drop, width: cfg_width, lock: cfg_lock,
               gain: cfg_gain, sel_gain: sel_gain};
    diff_c = (DIFF_W'(stc_cnt) >> cfg_drop) - (DIFF_W'(pcr_cnt) >> cfg_drop);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_diff  <= '0;
      s1_cfg   <= '0;
    end else begin
      s1_valid <= sample_valid;
      if (sample_valid) begin
        s1_diff <= diff_c;
        s1_cfg  <= cfg_in;
      end
    end
  end

  ts_pd_window #(.DIFF_W(DIFF_W), .CFG_W(CFG_W)) u_win_range (
    .diff(s1_diff), .thr(s1_cfg.width), .fits(fit_win)
  );

  ts_pd_window #(.DIFF_W(DIFF_W), .CFG_W(CFG_W)) u_win_lock (
    .diff(s1_diff), .thr(s1_cfg.lock), .fits(fit_lock)
  );

  ts_pd_scale #(.DIFF_W(DIFF_W), .CFG_W(CFG_W), .ERR_W(ERR_W)) u_scale (
    .diff(s1_diff), .width(s1_cfg.width), .gain(s1_cfg.gain),
    .sel_gain(s1_cfg.sel_gain), .err(err_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      err_out   <= '0;
      in_range  <= 1'b0;
      lock_flag <= 1'b0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        err_out   <= err_c;
        in_range  <= fit_win;
        lock_flag <= fit_lock;
      end
    end
  end
endmodule

// File: rtl/ts_pd_checker.sv
module ts_pd_checker #(
  parameter int ERR_W  = 16,
  parameter int DIFF_W = 43
) (
  input logic              clk,
  input logic              rst,
  input logic              sample_valid,
  input logic              out_valid,
  input logic [ERR_W-1:0]  err_out,
  input logic              in_range,
  input logic              lock_flag,
  input logic              s1_valid,
  input logic [DIFF_W-1:0] s1_diff
);
  assert_latency_R8: assert property (@(posedge clk) disable iff (rst)
    sample_valid |-> ##2 out_valid);

  assert_stage_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(s1_valid));

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> ($stable(err_out) && $stable(in_range) && $stable(lock_flag)));

  assert_sign_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && in_range) |-> (err_out[ERR_W-1] == $past(s1_diff[DIFF_W-1])));

  assert_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && (s1_diff == '0)) |=> (in_range && lock_flag));
endmodule

bind ts_phase_detector ts_pd_checker #(.ERR_W(ERR_W), .DIFF_W(DIFF_W)) u_chk (
  .clk(clk), .rst(rst), .sample_valid(sample_valid), .out_valid(out_valid),
  .err_out(err_out), .in_range(in_range), .lock_flag(lock_flag),
  .s1_valid(s1_valid), .s1_diff(s1_diff)
);

// File: tb/ts_phase_detector_tb.sv
module ts_phase_detector_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sample_valid = 1'b0;
  logic [32:0] stc_base = '0;
  logic [8:0]  stc_ext = '0;
  logic [32:0] pcr_base = '0;
  logic [8:0]  pcr_ext = '0;
  logic [3:0]  cfg_drop = '0, cfg_width = '0, cfg_lock = '0, cfg_gain = '0;
  logic        sel_gain = 1'b0;
  logic [15:0] err_out;
  logic        in_range, lock_flag, out_valid;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [15:0] exp_err;
  logic        exp_in, exp_lk;

  always #10 clk = ~clk;

  ts_phase_detector u_dut (
    .clk(clk), .rst(rst), .sample_valid(sample_valid),
    .stc_base(stc_base), .stc_ext(stc_ext), .pcr_base(pcr_base), .pcr_ext(pcr_ext),
    .cfg_drop(cfg_drop), .cfg_width(cfg_width), .cfg_lock(cfg_lock),
    .cfg_gain(cfg_gain), .sel_gain(sel_gain),
    .err_out(err_out), .in_range(in_range), .lock_flag(lock_flag), .out_valid(out_valid)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0h expected=%0h", tag, got, exp);
    end
  endtask

  function automatic bit in_win(input longint d, input int w);
    return (d >= -(64'sd1 <<< w)) && (d <= (64'sd1 <<< w) - 1);
  endfunction

  task automatic model(input logic [32:0] sb, input logic [8:0] se,
                       input logic [32:0] pb, input logic [8:0] pe,
                       input int d, input int n, input int m, input int g, input bit sel);
    longint cs, cp, sd, r;
    cs = longint'({31'b0, sb}) * 300 + longint'({55'b0, se});
    cp = longint'({31'b0, pb}) * 300 + longint'({55'b0, pe});
    sd = (cs >> d) - (cp >> d);
    exp_in = in_win(sd, n);
    exp_lk = in_win(sd, m);
    r = sd & ((64'sd1 <<< (n + 1)) - 1);
    if (r[n]) r = r - (64'sd1 <<< (n + 1));
    if (sel) r = r >>> g;
    exp_err = r[15:0];
  endtask

  task automatic sample(input string tag,
                        input logic [32:0] sb, input logic [8:0] se,
                        input logic [32:0] pb, input logic [8:0] pe,
                        input int d, input int n, input int m, input int g, input bit sel);
    model(sb, se, pb, pe, d, n, m, g, sel);
    @(negedge clk);
    stc_base = sb; stc_ext = se; pcr_base = pb; pcr_ext = pe;
    cfg_drop = 4'(d); cfg_width = 4'(n); cfg_lock = 4'(m); cfg_gain = 4'(g);
    sel_gain = sel; sample_valid = 1'b1;
    @(negedge clk);
    sample_valid = 1'b0;
    stc_base = ~sb; pcr_ext = 9'd7; cfg_width = 4'(n + 3); cfg_gain = 4'(g + 1);
    check({tag, " R8 early out_valid"}, 32'(out_valid), 32'd0);
    @(negedge clk);
    check({tag, " R8 out_valid"}, 32'(out_valid), 32'd1);
    check({tag, " err"}, 32'(err_out), 32'(exp_err));
    check({tag, " R4 in_range"}, 32'(in_range), 32'(exp_in));
    check({tag, " R5 lock"}, 32'(lock_flag), 32'(exp_lk));
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R10 err", 32'(err_out), 32'd0);
    check("R10 flags", {30'b0, in_range, lock_flag}, 32'd0);
    check("R10 out_valid", 32'(out_valid), 32'd0);
  endtask

  task automatic t_convert();
    sample("R1 zero", 33'd1000, 9'd150, 33'd1000, 9'd150, 0, 3, 0, 0, 0);
    sample("R1 ext carry", 33'd5, 9'd0, 33'd4, 9'd299, 0, 4, 0, 0, 0);
    sample("R1 max base", 33'h1FFFFFFFF, 9'd298, 33'h1FFFFFFFF, 9'd299, 0, 15, 15, 0, 0);
    sample("R1 base step", 33'h100000000, 9'd0, 33'h0FFFFFFFF, 9'd0, 0, 8, 9, 0, 0);
    check("R1 base step err", 32'(err_out), 32'h0000FF2C);
    sample("R1 base step wide", 33'h100000000, 9'd0, 33'h0FFFFFFFF, 9'd0, 0, 9, 8, 0, 0);
    check("R1 base step wide err", 32'(err_out), 32'd300);
  endtask

  task automatic t_window();
    sample("R4 top in", 33'd10, 9'd31, 33'd10, 9'd0, 0, 5, 15, 0, 0);
    sample("R4 top out", 33'd10, 9'd32, 33'd10, 9'd0, 0, 5, 15, 0, 0);
    check("R3 wrap to -32", 32'(err_out), 32'h0000FFE0);
    sample("R4 bottom in", 33'd10, 9'd8, 33'd10, 9'd40, 0, 5, 15, 0, 0);
    check("R3 -32", 32'(err_out), 32'h0000FFE0);
    sample("R4 bottom out", 33'd10, 9'd7, 33'd10, 9'd40, 0, 5, 15, 0, 0);
    check("R3 wrap to 31", 32'(err_out), 32'd31);
  endtask

  task automatic t_lock();
    sample("R5 lock only", 33'd20, 9'd100, 33'd20, 9'd0, 0, 3, 7, 0, 0);
    check("R5 in_range low", 32'(in_range), 32'd0);
    check("R5 lock high", 32'(lock_flag), 32'd1);
    sample("R5 range only", 33'd20, 9'd100, 33'd20, 9'd0, 0, 7, 3, 0, 0);
    check("R5 swapped", {30'b0, in_range, lock_flag}, 32'd2);
  endtask

  task automatic t_drop();
    sample("R2 drop hides", 33'd0, 9'd15, 33'd0, 9'd0, 4, 0, 0, 0, 0);
    check("R2 err zero", 32'(err_out), 32'd0);
    sample("R2 drop keeps", 33'd0, 9'd16, 33'd0, 9'd0, 4, 0, 0, 0, 0);
    check("R2 err one", 32'(err_out), 32'hFFFF);
    sample("R2 drop mixed", 33'd10, 9'd5, 33'd9, 9'd17, 3, 7, 4, 0, 0);
  endtask

  task automatic t_gain();
    sample("R6 neg floor", 33'd50, 9'd0, 33'd50, 9'd37, 0, 7, 15, 2, 1);
    check("R6 -10", 32'(err_out), 32'h0000FFF6);
    sample("R6 pos", 33'd50, 9'd37, 33'd50, 9'd0, 0, 7, 15, 2, 1);
    check("R6 9", 32'(err_out), 32'd9);
    sample("R6 full shift", 33'd50, 9'd0, 33'd50, 9'd37, 0, 15, 15, 15, 1);
    check("R6 -1", 32'(err_out), 32'hFFFF);
    sample("R7 gain ignored", 33'd50, 9'd0, 33'd50, 9'd37, 0, 7, 15, 2, 0);
    check("R7 -37", 32'(err_out), 32'h0000FFDB);
  endtask

  task automatic t_hold();
    sample("R9 base", 33'd77, 9'd60, 33'd77, 9'd10, 0, 6, 4, 0, 0);
    @(negedge clk);
    stc_base = 33'd3; stc_ext = 9'd200; pcr_base = 33'd900; cfg_width = 4'd0; cfg_lock = 4'd15;
    sel_gain = 1'b1; cfg_gain = 4'd5;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R9 out_valid low", 32'(out_valid), 32'd0);
      check("R9 err held", 32'(err_out), 32'(exp_err));
      check("R9 flags held", {30'b0, in_range, lock_flag}, {30'b0, exp_in, exp_lk});
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_convert();
    t_window();
    t_lock();
    t_drop();
    t_gain();
    t_hold();
    finish_run();
  end

  initial begin
    #(20 * 100000);
    checks++;
    failures++;
    $display("FAIL watchdog expired got=running expected=finished");
    finish_run();
  end
endmodule